// File: doc/BRIEF.md
# Scanline Horizontal Event Scheduler

The block keeps a free-running master cycle counter and a horizontal position counter. Both advance by two master cycles on every clock. Each clock therefore stands for one two-cycle step of the timing engine. From the horizontal position, the block derives the strobes that the rest of the system needs within a scanline:

- a video-unit tick and an interrupt-counter tick;
- an end-of-line query window;
- an HDMA transfer start and, on the first line only, an HDMA init start;
- a DRAM refresh that stalls the CPU.

Two slots are recomputed each time a line wraps: the HDMA init slot and the refresh slot. They are taken from the low three bits of the master counter at that moment, so their positions drift with the phase of the master clock from line to line. The video unit answers end-of-line queries with an acknowledge, and only an acknowledged query returns the horizontal counter to zero. A refresh asks the CPU for a five-cycle stall and holds a busy flag for the twenty steps it occupies. The counters keep stepping through that window.

Top module: `hline_event_sched`

## Requirements
- R1: While rst_ni is low, and in the first cycle after release, hcount_o and mcount_o are 0 and stall_busy_o is 0. The HDMA init slot returns to 12 and the refresh slot returns to 538.
- R2: In every cycle out of reset, mcount_o increases by exactly 2. hcount_o also increases by 2, except on a line wrap.
- R3: ppu_tick_o and irq_tick_o are high exactly in the cycles where hcount_o is a multiple of 4.
- R4: eol_check_o is high exactly when hcount_o is 1360, 1364 or 1368. hcount_o becomes 0 in the next cycle only when eol_ack_i is high in such a cycle. An acknowledge at any other position has no effect.
- R5: hdma_xfer_o is high exactly when hcount_o is 1104 and scanline_i is less than vblank_line_i.
- R6: hdma_init_o is high exactly when scanline_i is 0 and hcount_o equals 12 plus (M mod 8). M is the value of mcount_o in the cycle where hcount_o was last 0, which is 0 after reset.
- R7: cpu_stall_o is high exactly when hcount_o equals 538 minus (M mod 8), with M as in R6. stall_cycles_o is 5 in that cycle and 0 otherwise.
- R8: stall_busy_o is high in the refresh cycle and in the 19 cycles after it (20 steps in all), and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one two-cycle step per edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scanline_i | input | 9 | Current scanline from the video unit |
| vblank_line_i | input | 9 | First vertical-blank scanline |
| eol_ack_i | input | 1 | Video unit confirms end of line |
| ppu_tick_o | output | 1 | Video-unit tick strobe |
| irq_tick_o | output | 1 | Interrupt-counter tick strobe |
| eol_check_o | output | 1 | End-of-line query window |
| hdma_xfer_o | output | 1 | HDMA transfer start strobe |
| hdma_init_o | output | 1 | HDMA init start strobe (line 0) |
| cpu_stall_o | output | 1 | Refresh stall request strobe |
| stall_cycles_o | output | 3 | CPU cycles to stall, valid with cpu_stall_o |
| stall_busy_o | output | 1 | Refresh window in progress |
| mcount_o | output | 32 | Master cycle counter |
| hcount_o | output | 12 | Horizontal position counter |

## Verification
Some strobes fall in the same cycle as a tick. When the master phase is 2 or 6 at a line start, the refresh slot lands on a multiple of 4, so it coincides with a video tick. The HDMA init slot coincides with a tick when the phase is 0 or 4. The bench sets these phases by ending successive lines at the different acknowledge positions, which shifts the master phase by 2 or 6 per line. It compares every strobe in every cycle against a model that tracks the positions on its own. Acknowledges outside the query window are also driven, and the bench judges them by checking that the line does not wrap.

// File: rtl/hline_sched_pkg.sv
package hline_sched_pkg;
  localparam int unsigned STEP          = 2;
  localparam int unsigned EOL_POS0      = 1360;
  localparam int unsigned EOL_POS1      = 1364;
  localparam int unsigned EOL_POS2      = 1368;
  localparam int unsigned XFER_POS      = 1104;
  localparam int unsigned INIT_BASE     = 12;
  localparam int unsigned REFRESH_BASE  = 538;
  localparam int unsigned PHASE_BITS    = 3;
  localparam int unsigned STALL_STEPS   = 20;
  localparam int unsigned STALL_CPU     = 5;
  localparam int unsigned TICK_MASK     = 3;
endpackage

// File: rtl/hline_pos_ctr.sv
module hline_pos_ctr
  import hline_sched_pkg::*;
#(
  parameter int unsigned MW = 32,
  parameter int unsigned HW = 12
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wrap_i,
  output logic [MW-1:0]         mcount_o,
  output logic [HW-1:0]         hcount_o,
  output logic [PHASE_BITS-1:0] next_phase_o
);
  logic [MW-1:0] m_q, m_nxt;
  logic [HW-1:0] h_q, h_nxt;

  assign m_nxt = m_q + MW'(STEP);
  assign h_nxt = wrap_i ? '0 : h_q + HW'(STEP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_q <= '0;
      h_q <= '0;
    end else begin
      m_q <= m_nxt;
      h_q <= h_nxt;
    end
  end

  assign mcount_o     = m_q;
  assign hcount_o     = h_q;
  assign next_phase_o = m_nxt[PHASE_BITS-1:0];
endmodule

// File: rtl/hline_slot_regs.sv
module hline_slot_regs
  import hline_sched_pkg::*;
#(
  parameter int unsigned HW = 12
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wrap_i,
  input  logic [PHASE_BITS-1:0] phase_i,
  output logic [HW-1:0]         init_pos_o,
  output logic [HW-1:0]         refresh_pos_o
);
  logic [HW-1:0] init_q, ref_q;

  // phase sampled from master value seen at h == 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= HW'(INIT_BASE);
      ref_q  <= HW'(REFRESH_BASE);
    end else if (wrap_i) begin
      init_q <= HW'(INIT_BASE) + HW'(phase_i);
      ref_q  <= HW'(REFRESH_BASE) - HW'(phase_i);
    end
  end

  assign init_pos_o    = init_q;
  assign refresh_pos_o = ref_q;
endmodule

// File: rtl/hline_refresh_stall.sv
module hline_refresh_stall
  import hline_sched_pkg::*;
#(
  parameter int unsigned STEPS = STALL_STEPS
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(STEPS);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (hit_i)         cnt_q <= CW'(STEPS - 1);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = hit_i | (cnt_q != '0);
endmodule

// File: rtl/hline_event_sched.sv
module hline_event_sched
  import hline_sched_pkg::*;
#(
  parameter int unsigned MW  = 32,
  parameter int unsigned HW  = 12,
  parameter int unsigned SLW = 9
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [SLW-1:0] scanline_i,
  input  logic [SLW-1:0] vblank_line_i,
  input  logic           eol_ack_i,
  output logic           ppu_tick_o,
  output logic           irq_tick_o,
  output logic           eol_check_o,
  output logic           hdma_xfer_o,
  output logic           hdma_init_o,
  output logic           cpu_stall_o,
  output logic [2:0]     stall_cycles_o,
  output logic           stall_busy_o,
  output logic [MW-1:0]  mcount_o,
  output logic [HW-1:0]  hcount_o
);
  logic                  wrap;
  logic [PHASE_BITS-1:0] phase;
  logic [HW-1:0]         init_pos, ref_pos;

  hline_pos_ctr #(.MW(MW), .HW(HW)) u_pos (
    .clk_i, .rst_ni, .wrap_i(wrap),
    .mcount_o, .hcount_o, .next_phase_o(phase)
  );

  hline_slot_regs #(.HW(HW)) u_slots (
    .clk_i, .rst_ni, .wrap_i(wrap), .phase_i(phase),
    .init_pos_o(init_pos), .refresh_pos_o(ref_pos)
  );

  hline_refresh_stall #(.STEPS(STALL_STEPS)) u_stall (
    .clk_i, .rst_ni, .hit_i(cpu_stall_o), .busy_o(stall_busy_o)
  );

  assign eol_check_o = (hcount_o == HW'(EOL_POS0)) ||
                       (hcount_o == HW'(EOL_POS1)) ||
                       (hcount_o == HW'(EOL_POS2));
  assign wrap        = eol_check_o & eol_ack_i;

  assign ppu_tick_o  = (hcount_o & HW'(TICK_MASK)) == '0;
  assign irq_tick_o  = ppu_tick_o;
  assign hdma_xfer_o = (hcount_o == HW'(XFER_POS)) && (scanline_i < vblank_line_i);
  assign hdma_init_o = (hcount_o == init_pos) && (scanline_i == '0);
  assign cpu_stall_o = (hcount_o == ref_pos);
  assign stall_cycles_o = cpu_stall_o ? 3'(STALL_CPU) : 3'd0;
endmodule

// File: rtl/hline_event_sched_chk.sv
module hline_event_sched_chk #(
  parameter int unsigned MW = 32,
  parameter int unsigned HW = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          eol_ack_i,
  input logic          eol_check_o,
  input logic          ppu_tick_o,
  input logic          cpu_stall_o,
  input logic          stall_busy_o,
  input logic [MW-1:0] mcount_o,
  input logic [HW-1:0] hcount_o
);
  // R2
  mcount_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> mcount_o == $past(mcount_o) + MW'(2));
  // R4
  wrap_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eol_check_o && eol_ack_i) |=> hcount_o == '0);
  // R4
  no_wrap_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(eol_check_o && eol_ack_i) |=> hcount_o == $past(hcount_o) + HW'(2));
  // R3
  tick_alt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ppu_tick_o && !(eol_check_o && eol_ack_i)) |=> !ppu_tick_o);
  // R8
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stall_busy_o) |-> cpu_stall_o);
  // R8
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_stall_o |=> stall_busy_o);
endmodule

bind hline_event_sched hline_event_sched_chk #(.MW(MW), .HW(HW)) u_chk (
  .clk_i, .rst_ni, .eol_ack_i, .eol_check_o, .ppu_tick_o,
  .cpu_stall_o, .stall_busy_o, .mcount_o, .hcount_o
);

// File: tb/hline_event_sched_bench.sv
module hline_event_sched_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [8:0]  scanline_i = '0;
  logic [8:0]  vblank_line_i = 9'd3;
  logic        eol_ack_i = 1'b0;
  logic        ppu_tick_o, irq_tick_o, eol_check_o, hdma_xfer_o, hdma_init_o;
  logic        cpu_stall_o, stall_busy_o;
  logic [2:0]  stall_cycles_o;
  logic [31:0] mcount_o;
  logic [11:0] hcount_o;

  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  hline_event_sched u_hline_event_sched (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int eol_target(int line);
    case (line % 3)
      0: return 1360;
      1: return 1364;
      default: return 1368;
    endcase
  endfunction

  initial begin
    int eh, einit, eref, ebusy, line, sl;
    longint unsigned em;
    bit isq, stall_e, wrap_e;
    repeat (3) @(negedge clk_i);
    // R1 during reset
    chk(hcount_o == 0, "R1 hcount", hcount_o, 0);
    chk(mcount_o == 0, "R1 mcount", mcount_o, 0);
    chk(stall_busy_o == 0, "R1 busy", stall_busy_o, 0);
    rst_ni = 1'b1;
    eh = 0; em = 0; einit = 12; eref = 538; ebusy = 0; line = 0;
    while (line < 12) begin
      sl = line % 5;
      scanline_i = 9'(sl);
      isq = (eh == 1360) || (eh == 1364) || (eh == 1368);
      // ack at 700 must be ignored (R4)
      eol_ack_i = (eh == eol_target(line)) || (eh == 700);
      #1;
      stall_e = (eh == eref);
      chk(int'(hcount_o) == eh, "R2/R4 hcount", hcount_o, eh);
      chk(mcount_o == 32'(em), "R2 mcount", mcount_o, em);
      chk(ppu_tick_o == (eh % 4 == 0), "R3 ppu_tick", ppu_tick_o, eh % 4 == 0);
      chk(irq_tick_o == (eh % 4 == 0), "R3 irq_tick", irq_tick_o, eh % 4 == 0);
      chk(eol_check_o == isq, "R4 eol_check", eol_check_o, isq);
      chk(hdma_xfer_o == (eh == 1104 && sl < 3), "R5 hdma_xfer", hdma_xfer_o, eh == 1104 && sl < 3);
      chk(hdma_init_o == (sl == 0 && eh == einit), "R6 hdma_init", hdma_init_o, sl == 0 && eh == einit);
      chk(cpu_stall_o == stall_e, "R7 cpu_stall", cpu_stall_o, stall_e);
      chk(int'(stall_cycles_o) == (stall_e ? 5 : 0), "R7 stall_cycles", stall_cycles_o, stall_e ? 5 : 0);
      chk(stall_busy_o == (stall_e || ebusy > 0), "R8 stall_busy", stall_busy_o, stall_e || ebusy > 0);
      wrap_e = isq && eol_ack_i;
      em += 2;
      if (stall_e) ebusy = 19;
      else if (ebusy > 0) ebusy--;
      if (wrap_e) begin
        eh = 0;
        einit = 12 + int'(em % 8);
        eref = 538 - int'(em % 8);
        line++;
      end else eh += 2;
      @(negedge clk_i);
    end
    // R1 reset mid-line returns to start values
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b0;
    eol_ack_i = 1'b0;
    #1;
    chk(hcount_o == 0, "R1 hcount mid-run", hcount_o, 0);
    chk(mcount_o == 0, "R1 mcount mid-run", mcount_o, 0);
    chk(stall_busy_o == 0, "R1 busy mid-run", stall_busy_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    scanline_i = 9'd0;
    // first line after reset: init slot 12, refresh slot 538
    for (int c = 0; c < 600; c++) begin
      #1;
      chk(hdma_init_o == (c * 2 == 12), "R1/R6 init slot after reset", hdma_init_o, c * 2 == 12);
      chk(cpu_stall_o == (c * 2 == 538), "R1/R7 refresh slot after reset", cpu_stall_o, c * 2 == 538);
      @(negedge clk_i);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule